// File: doc/BRIEF.md
# Three-Way Split Integer Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Each operand is cut into three limbs of N/3 bits. Nine limb products would be needed by the schoolbook method. Here six are enough: the three diagonal products and three products of pairwise limb sums. A subtractor stage then recovers the cross-term coefficients, and a final shifted sum places the five coefficients at multiples of N/3 bits.

A caller presents the operands together with a one-cycle `start` request while the engine is idle. The six limb products are formed by six shift-add units working side by side, one multiplier bit per clock. Two further register stages form the coefficients and the final sum. Completion is flagged by a one-cycle `done` pulse, and the product output keeps its value until the next result replaces it.

The interface is a plain control pair, with no stream flow control. A request that arrives while a computation is in flight is dropped. The engine is idle again in the same cycle that `done` is high, so a new request may be issued in that cycle. N must be a multiple of 3 and at least 3; any other value stops elaboration with an error.

Top module: `karat3_mul`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied and after its release, `done` is 0 and `prod` is 0 until the first result is produced.
- R2: For every pair of unsigned operands, the result presented with `done` equals the full 2N-bit product `a*b` of the operands sampled on the accepted `start` edge.
- R3: `done` is high for exactly one cycle. It rises after the (N/3+3)th rising clock edge that follows the edge on which `start` was accepted. That is N/3+1 shift-add steps plus one coefficient stage plus one summing stage.
- R4: `prod` changes only in a cycle in which `done` is high, and holds its value in every other cycle, including idle cycles after a result.
- R5: While a computation is in flight, `start` and the operand inputs are ignored: the result and its timing are those of the request that was accepted.
- R6: A `start` presented in the cycle in which `done` is high is accepted as a new request. Its result follows with the latency of R3.
- R7: At the default width N=12, operands at their extremes give exact products. This covers all-ones times all-ones, top bit only, and alternating bit patterns, where every limb sum carries into its extra bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only when the engine is idle |
| a | input | N | Unsigned multiplicand, sampled with an accepted `start` |
| b | input | N | Unsigned multiplier, sampled with an accepted `start` |
| done | output | 1 | One-cycle pulse: `prod` holds a new result |
| prod | output | 2N | Unsigned product, held until the next result |

## Verification
Two events can fall in the same cycle: the `done` pulse that ends one computation and the acceptance of the next `start`. The bench provokes this on every vector of the full 6-bit sweep by raising `start` with the next operands in the very cycle that `done` is observed. In the cycle that follows, it judges that `done` has dropped and that `prod` still shows the old product. It then counts the edges to the next pulse and compares the new product. A separate test holds `start` high with other operands through every busy cycle, to show those requests are dropped.

// File: rtl/karat3_pkg.sv
package karat3_pkg;

  // Sequencer phases of the multiplier
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for a request
    ST_MUL  = 2'd1,  // shift-add units stepping
    ST_COEF = 2'd2,  // coefficient registers load
    ST_SUM  = 2'd3   // shifted sum loads the result
  } karat3_state_t;

  // Number of sub-products and coefficients of a one-level three-way split
  localparam int NUM_SUB  = 6;
  localparam int NUM_COEF = 5;

endpackage

// File: rtl/karat3_split.sv
// Cuts both operands into three limbs and forms the six operand pairs
// feeding the sub-product units:
//   0: a0*b0   1: a1*b1   2: a2*b2
//   3: (a0+a1)(b0+b1)   4: (a0+a2)(b0+b2)   5: (a1+a2)(b1+b2)
module karat3_split #(
  parameter int N = 12
) (
  input  logic [N-1:0]                         a,
  input  logic [N-1:0]                         b,
  output logic [karat3_pkg::NUM_SUB-1:0][N/3:0] ox,
  output logic [karat3_pkg::NUM_SUB-1:0][N/3:0] oy
);
  localparam int L = N / 3;
  localparam int W = L + 1;

  logic [2:0][L-1:0] la, lb;

  for (genvar k = 0; k < 3; k++) begin : g_limb
    assign la[k] = a[k*L +: L];
    assign lb[k] = b[k*L +: L];
  end

  always_comb begin
    ox[0] = W'(la[0]);
    oy[0] = W'(lb[0]);
    ox[1] = W'(la[1]);
    oy[1] = W'(lb[1]);
    ox[2] = W'(la[2]);
    oy[2] = W'(lb[2]);
    ox[3] = W'(la[0]) + W'(la[1]);
    oy[3] = W'(lb[0]) + W'(lb[1]);
    ox[4] = W'(la[0]) + W'(la[2]);
    oy[4] = W'(lb[0]) + W'(lb[2]);
    ox[5] = W'(la[1]) + W'(la[2]);
    oy[5] = W'(lb[1]) + W'(lb[2]);
  end

endmodule

// File: rtl/karat3_seqmul.sv
// Shift-add multiplier: one multiplier bit per step, W steps for a full
// W x W product. Operands load on 'load'; 'step' advances one bit.
module karat3_seqmul #(
  parameter int W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic [PW-1:0] mcand;
  logic [W-1:0]  mplier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p      <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else if (load) begin
      p      <= '0;
      mcand  <= PW'(x);
      mplier <= y;
    end else if (step) begin
      if (mplier[0]) p <= p + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

endmodule

// File: rtl/karat3_coef.sv
// Recovers the five coefficients from the six sub-products. Every
// coefficient is non-negative and below 3*(2^L-1)^2 < 2^(2L+2), so the
// arithmetic modulo 2^PW yields the exact value.
module karat3_coef #(
  parameter int N = 12
) (
  input  logic [karat3_pkg::NUM_SUB-1:0][2*(N/3)+1:0]  p,
  output logic [karat3_pkg::NUM_COEF-1:0][2*(N/3)+1:0] c
);
  always_comb begin
    c[0] = p[0];
    c[1] = p[3] - p[0] - p[1];
    c[2] = p[4] + p[1] - p[0] - p[2];
    c[3] = p[5] - p[1] - p[2];
    c[4] = p[2];
  end

endmodule

// File: rtl/karat3_shiftsum.sv
// Places coefficient k at bit offset k*L and adds the five terms.
module karat3_shiftsum #(
  parameter int N = 12
) (
  input  logic [karat3_pkg::NUM_COEF-1:0][2*(N/3)+1:0] c,
  output logic [2*N-1:0]                               s
);
  localparam int L  = N / 3;
  localparam int RW = 2 * N;

  logic [karat3_pkg::NUM_COEF-1:0][RW-1:0] term;

  for (genvar k = 0; k < karat3_pkg::NUM_COEF; k++) begin : g_term
    assign term[k] = RW'(c[k]) << (k * L);
  end

  always_comb begin
    s = '0;
    for (int k = 0; k < karat3_pkg::NUM_COEF; k++) s = s + term[k];
  end

endmodule

// File: rtl/karat3_mul.sv
module karat3_mul #(
  parameter int N = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           done,
  output logic [2*N-1:0] prod
);
  import karat3_pkg::*;

  localparam int L  = N / 3;
  localparam int W  = L + 1;
  localparam int PW = 2 * W;
  localparam int SW = $clog2(W + 1);

  if ((N % 3) != 0 || N < 3) begin : g_bad_width
    $error("karat3_mul: N must be a positive multiple of 3");
  end

  karat3_state_t state;
  logic [SW-1:0] step_cnt;
  logic          accept;
  logic          idle_w;
  logic          stepping;

  logic [NUM_SUB-1:0][W-1:0]   op_x, op_y;
  logic [NUM_SUB-1:0][PW-1:0]  sub_p;
  logic [NUM_COEF-1:0][PW-1:0] coef_d, coef_q;
  logic [2*N-1:0]              sum_d;

  assign idle_w   = (state == ST_IDLE);
  assign accept   = idle_w && start;
  assign stepping = (state == ST_MUL);

  karat3_split #(.N(N)) u_split (
    .a (a),
    .b (b),
    .ox(op_x),
    .oy(op_y)
  );

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_unit
    karat3_seqmul #(.W(W)) u_mul (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .step (stepping),
      .x    (op_x[i]),
      .y    (op_y[i]),
      .p    (sub_p[i])
    );
  end

  karat3_coef #(.N(N)) u_coef (
    .p(sub_p),
    .c(coef_d)
  );

  karat3_shiftsum #(.N(N)) u_sum (
    .c(coef_q),
    .s(sum_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      coef_q   <= '0;
      prod     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_MUL;
            step_cnt <= '0;
          end
        end
        ST_MUL: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == SW'(W - 1)) state <= ST_COEF;
        end
        ST_COEF: begin
          coef_q <= coef_d;
          state  <= ST_SUM;
        end
        ST_SUM: begin
          prod  <= sum_d;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/karat3_chk.sv
module karat3_chk #(
  parameter int N = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic           done,
  input logic [2*N-1:0] prod,
  input logic           idle
);
  localparam int LAT = N / 3 + 3;

  logic [N-1:0]   a_cap, b_cap;
  logic [2*N-1:0] ref_prod;
  int             lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cap   <= '0;
      b_cap   <= '0;
      lat_cnt <= 0;
    end else if (idle && start) begin
      a_cap   <= a;
      b_cap   <= b;
      lat_cnt <= 0;
    end else if (!idle) begin
      lat_cnt <= lat_cnt + 1;
    end
  end

  assign ref_prod = (2*N)'(a_cap) * (2*N)'(b_cap);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done);

  // R2
  product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> prod == ref_prod);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_cnt == LAT);

  // R4
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prod) |-> done);

  // R6
  chain_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !idle);

endmodule

bind karat3_mul karat3_chk #(.N(N)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .a    (a),
  .b    (b),
  .done (done),
  .prod (prod),
  .idle (idle_w)
);

// File: tb/karat3_mul_test.sv
`timescale 1ns/1ps
module karat3_mul_test;

  localparam int NS  = 6;
  localparam int LS  = NS / 3 + 3;
  localparam int NW  = 12;
  localparam int LW  = NW / 3 + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic            start = 1'b0;
  logic [NS-1:0]   a = '0, b = '0;
  logic            done;
  logic [2*NS-1:0] prod;

  logic            start_w = 1'b0;
  logic [NW-1:0]   a_w = '0, b_w = '0;
  logic            done_w;
  logic [2*NW-1:0] prod_w;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  karat3_mul #(.N(NS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .done(done), .prod(prod)
  );

  karat3_mul #(.N(NW)) uut_wide (
    .clk(clk), .rst_n(rst_n), .start(start_w), .a(a_w), .b(b_w),
    .done(done_w), .prod(prod_w)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // count edges until done is seen at a falling edge
  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 40) begin
      tick();
      cyc++;
    end
  endtask

  task automatic wait_done_w(output int cyc);
    cyc = 0;
    while (!done_w && cyc < 40) begin
      tick();
      cyc++;
    end
  endtask

  task automatic wide_op(input logic [NW-1:0] x, input logic [NW-1:0] y);
    int cyc;
    start_w = 1'b1; a_w = x; b_w = y;
    tick();
    start_w = 1'b0;
    wait_done_w(cyc);
    check("R3 wide latency", cyc, LW);
    check("R7 wide product", prod_w, longint'(x) * longint'(y));
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    longint prev;
    longint held;

    // R1: reset state
    repeat (3) tick();
    check("R1 done in reset", done, 0);
    check("R1 prod in reset", prod, 0);
    rst_n = 1'b1;
    tick();
    tick();
    check("R1 done after reset", done, 0);
    check("R1 prod after reset", prod, 0);

    // R5: start held high with other operands through every busy cycle
    start = 1'b1; a = 6'd13; b = 6'd57;
    tick();
    a = 6'd63; b = 6'd63;
    cyc = 0;
    while (!done && cyc < 40) begin
      if (cyc == LS - 1) begin
        tick();
        start = 1'b0;
      end else begin
        tick();
      end
      cyc++;
    end
    start = 1'b0;
    check("R5 latency with start held", cyc, LS);
    check("R5 busy start ignored", prod, 13 * 57);
    held = prod;
    repeat (3) begin
      tick();
      check("R4 idle done low", done, 0);
      check("R4 idle prod held", prod, held);
    end

    // R2, R3, R4, R6: exhaustive sweep chained in the done cycle
    prev = held;
    for (int idx = 0; idx < 4096; idx++) begin
      logic [NS-1:0] x, y;
      x = NS'(idx >> 6);
      y = NS'(idx & 63);
      start = 1'b1; a = x; b = y;
      tick();
      start = 1'b0;
      check("R3 done single cycle", done, 0);
      check("R4 prod held after done", prod, prev);
      wait_done(cyc);
      check("R3 R6 latency", cyc, LS);
      check("R2 R6 product", prod, longint'(x) * longint'(y));
      prev = longint'(x) * longint'(y);
    end
    tick();
    check("R3 final pulse ends", done, 0);

    // R7: corner operands at the default width
    wide_op(12'hFFF, 12'hFFF);
    wide_op(12'h800, 12'h800);
    wide_op(12'hFFF, 12'h001);
    wide_op(12'h000, 12'hFFF);
    wide_op(12'hAAA, 12'h555);
    wide_op(12'h924, 12'h6DB);
    wide_op(12'h0F0, 12'hF0F);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule